// File: doc/BRIEF.md
# Halt and wake-up controller

This block governs a core's low-power halt state. A halt command stops the system-clock enable and marks the power-down flag. While halted, the block watches four wake sources: an external reset, a watchdog overflow, newly raised interrupt requests and falling edges on mask-selected bits of an 8-bit port.

Any wake restarts the clock and runs a fixed settle period of 1024 cycles before the core may run again. After the settle period the block picks one of four outcomes:

- a plain resume at the next instruction;
- a vectored interrupt entry, one cycle later than a plain resume;
- a warm reset after a watchdog time-out;
- a silent return to run after an external reset, which reinitialises the flags.

The power-down and time-out flags let software tell afterwards why the core restarted. An interrupt that was already pending when the halt began cannot wake the core.

The input `clk` is an always-running reference clock. The block's registers use it throughout, including the settle counter. `sys_clk_en` gates the clock to the rest of the core, and `core_run` tells the core that it may execute.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After power-up reset (`rst_n` low), `sys_clk_en` = 1, `core_run` = 1, `pd_flag` = 0, `to_flag` = 0, and no strobe is high.
- R2: A `halt_cmd` sampled while `core_run` = 1 gives `sys_clk_en` = 0, `core_run` = 0, `pd_flag` = 1 and `to_flag` = 0 from the next cycle. A `halt_cmd` sampled while `core_run` = 0 has no effect.
- R3: A `wdt_clr` sampled while running clears `pd_flag` from the next cycle. If `halt_cmd` is high in the same cycle, the halt wins and `pd_flag` becomes 1.
- R4: While halted, a port bit wakes the core when it reads 1 in one cycle and 0 in the next, provided its `port_wake_mask` bit is 1. Falling edges on bits whose mask bit is 0, and rising edges on any bit, do not wake.
- R5: Let E be the clock edge that samples a wake. `sys_clk_en` is 1 from E onward and `core_run` stays 0 until edge E+1024. For a plain resume, `core_run` rises at E+1024 and `resume_stb` is high for exactly the one cycle after E+1024.
- R6: While halted, an `irq_req` bit that was 0 at the halt-entry edge wakes the core. When several such bits are set, the lowest index is the wake source. If that bit's `irq_en` is 0, or `stack_full` is 1 at edge E, the outcome is a plain resume.
- R7: If the waking interrupt's `irq_en` bit is 1 and `stack_full` is 0 at edge E, then `core_run` rises at E+1025 and `irq_take_stb` is high for the one cycle after E+1025. `resume_stb` stays low for this wake.
- R8: An `irq_req` bit that was already 1 at the halt-entry edge cannot wake the core for the rest of that halt.
- R9: A `wdt_ovf` sampled while halted sets `to_flag` at E and leaves `pd_flag` at 1. In place of `resume_stb`, it pulses `warm_rst_stb` in the cycle after E+1024.
- R10: An `ext_rst` sampled in any state clears both flags and drops `core_run` at the next edge, then starts a 1024-cycle settle period. `core_run` returns at the end of that period and no strobe is raised.
- R11: While halted, wake sources rank as follows: `ext_rst` first, then `wdt_ovf`, then interrupts, then port edges. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| ext_rst | input | 1 | External reset request, synchronous, active high |
| halt_cmd | input | 1 | Enter halt (one-cycle command) |
| wdt_clr | input | 1 | Clear-watchdog command; clears the power-down flag |
| wdt_ovf | input | 1 | Watchdog overflow |
| port_in | input | PORT_W | Port pin levels |
| port_wake_mask | input | PORT_W | Per-bit wake enable for falling edges |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| sys_clk_en | output | 1 | System clock enable (0 only while halted) |
| core_run | output | 1 | Core may execute |
| resume_stb | output | 1 | Resume at the next instruction |
| irq_take_stb | output | 1 | Enter the interrupt vector |
| warm_rst_stb | output | 1 | Reset program counter and stack pointer only |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |

## Verification
The assertions check the following on every cycle:

- the effect of a halt command on the clock enable and the flags, and that `pd_flag` stays set while halted;
- flag clearing by `wdt_clr` and `ext_rst`;
- that the settle counter cannot leave early;
- that strobes are mutually exclusive and appear only as `core_run` rises;
- that a warm reset always carries a set `to_flag`.

The bench scenarios cover what needs history and stimulus: the exact 1024- and 1025-cycle latencies, the choice between resume and vectored entry under enable and stack-full conditions, and lowest-index selection. They also cover barring of interrupts that were pending at halt entry, masked and rising port edges, and the ranking of simultaneous wake sources.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int PORT_W = 8,
  parameter int IRQ_N = 4,
  parameter int SETTLE_CYCLES = 1024,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              halt_cmd,
  input  logic              wdt_clr,
  input  logic              wdt_ovf,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_mask,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              stack_full,
  output logic              sys_clk_en,
  output logic              core_run,
  output logic              resume_stb,
  output logic              irq_take_stb,
  output logic              warm_rst_stb,
  output logic              pd_flag,
  output logic              to_flag
);

  localparam logic [1:0] ST_RUN    = 2'd0;
  localparam logic [1:0] ST_HALT   = 2'd1;
  localparam logic [1:0] ST_SETTLE = 2'd2;
  localparam logic [1:0] ST_VECDLY = 2'd3;

  localparam logic [1:0] WK_PLAIN = 2'd0;
  localparam logic [1:0] WK_TAKE  = 2'd1;
  localparam logic [1:0] WK_WARM  = 2'd2;
  localparam logic [1:0] WK_INIT  = 2'd3;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [1:0]        st;
  logic [1:0]        cause;
  logic [CNT_W-1:0]  cnt;
  logic [PORT_W-1:0] port_q;
  logic [IRQ_N-1:0]  irq_armed;

  logic [PORT_W-1:0] port_fall;
  logic [IRQ_N-1:0]  irq_hit;
  logic [IRQ_N-1:0]  irq_first;
  logic              take_ok;

  assign port_fall  = port_q & ~port_in & port_wake_mask;
  assign irq_hit    = irq_req & irq_armed;
  assign irq_first  = irq_hit & (~irq_hit + IRQ_N'(1));
  assign take_ok    = |(irq_first & irq_en) && !stack_full;

  assign sys_clk_en = (st != ST_HALT);
  assign core_run   = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_RUN;
      cause        <= WK_PLAIN;
      cnt          <= '0;
      port_q       <= '0;
      irq_armed    <= '0;
      pd_flag      <= 1'b0;
      to_flag      <= 1'b0;
      resume_stb   <= 1'b0;
      irq_take_stb <= 1'b0;
      warm_rst_stb <= 1'b0;
    end else begin
      port_q       <= port_in;
      resume_stb   <= 1'b0;
      irq_take_stb <= 1'b0;
      warm_rst_stb <= 1'b0;
      if (ext_rst) begin
        st      <= ST_SETTLE;
        cause   <= WK_INIT;
        cnt     <= '0;
        pd_flag <= 1'b0;
        to_flag <= 1'b0;
      end else begin
        case (st)
          ST_RUN: begin
            if (halt_cmd) begin
              st        <= ST_HALT;
              pd_flag   <= 1'b1;
              to_flag   <= 1'b0;
              irq_armed <= ~irq_req;
            end else if (wdt_clr) begin
              pd_flag <= 1'b0;
            end
          end
          ST_HALT: begin
            if (wdt_ovf) begin
              st      <= ST_SETTLE;
              cause   <= WK_WARM;
              cnt     <= '0;
              to_flag <= 1'b1;
            end else if (|irq_hit) begin
              st    <= ST_SETTLE;
              cause <= take_ok ? WK_TAKE : WK_PLAIN;
              cnt   <= '0;
            end else if (|port_fall) begin
              st    <= ST_SETTLE;
              cause <= WK_PLAIN;
              cnt   <= '0;
            end
          end
          ST_SETTLE: begin
            if (cnt == CNT_LAST) begin
              cnt <= '0;
              case (cause)
                WK_TAKE:  st <= ST_VECDLY;
                WK_PLAIN: begin st <= ST_RUN; resume_stb <= 1'b1; end
                WK_WARM:  begin st <= ST_RUN; warm_rst_stb <= 1'b1; end
                default:  st <= ST_RUN;
              endcase
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: begin
            st           <= ST_RUN;
            irq_take_stb <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/halt_wake_ctrl_chk.sv
module halt_wake_ctrl_chk #(
  parameter int SETTLE_CYCLES = 1024,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_rst,
  input logic             halt_cmd,
  input logic             wdt_clr,
  input logic             sys_clk_en,
  input logic             core_run,
  input logic             resume_stb,
  input logic             irq_take_stb,
  input logic             warm_rst_stb,
  input logic             pd_flag,
  input logic             to_flag,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  // R2
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && halt_cmd && !ext_rst |=> !sys_clk_en && !core_run && pd_flag && !to_flag);

  // R2
  halted_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en |-> pd_flag);

  // R3
  clr_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && wdt_clr && !halt_cmd && !ext_rst |=> !pd_flag);

  // R5
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 && cnt != LAST |=> st == 2'd2);

  // R5
  strobe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb || irq_take_stb || warm_rst_stb) |-> core_run);

  // R5
  rise_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(sys_clk_en));

  // R7
  take_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_stb |-> $past(st) == 2'd3);

  // R9
  warm_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_stb |-> to_flag);

  // R10
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> !pd_flag && !to_flag && !core_run);

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_stb, irq_take_stb, warm_rst_stb}));

endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .halt_cmd(halt_cmd), .wdt_clr(wdt_clr),
  .sys_clk_en(sys_clk_en), .core_run(core_run), .resume_stb(resume_stb),
  .irq_take_stb(irq_take_stb), .warm_rst_stb(warm_rst_stb), .pd_flag(pd_flag),
  .to_flag(to_flag), .st(st), .cnt(cnt)
);

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;
  localparam int S = 1024;
  localparam int EV_RESUME = 0;
  localparam int EV_TAKE = 1;
  localparam int EV_WARM = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic ext_rst = 0, halt_cmd = 0, wdt_clr = 0, wdt_ovf = 0, stack_full = 0;
  logic [7:0] port_in = 8'hFF;
  logic [7:0] port_wake_mask = 8'h0F;
  logic [3:0] irq_req = 0, irq_en = 0;
  logic sys_clk_en, core_run, resume_stb, irq_take_stb, warm_rst_stb, pd_flag, to_flag;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  typedef struct { int kind; int at; string tag; } ev_t;
  ev_t sb[$];

  halt_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .halt_cmd(halt_cmd), .wdt_clr(wdt_clr),
    .wdt_ovf(wdt_ovf), .port_in(port_in), .port_wake_mask(port_wake_mask),
    .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
    .sys_clk_en(sys_clk_en), .core_run(core_run), .resume_stb(resume_stb),
    .irq_take_stb(irq_take_stb), .warm_rst_stb(warm_rst_stb),
    .pd_flag(pd_flag), .to_flag(to_flag)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int delay, input string tag);
    ev_t e;
    e.kind = kind; e.at = cyc + delay; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
    step(1);
  endtask

  task automatic do_halt;
    halt_cmd = 1; step(1); halt_cmd = 0;
  endtask

  int kind_seen;
  ev_t popped;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resume_stb || irq_take_stb || warm_rst_stb) begin
        kind_seen = resume_stb ? EV_RESUME : (irq_take_stb ? EV_TAKE : EV_WARM);
        if (sb.size() == 0) begin
          chk(0, "R11 unexpected strobe", kind_seen, -1);
        end else begin
          popped = sb.pop_front();
          chk(popped.kind == kind_seen, popped.tag, kind_seen, popped.kind);
          chk(popped.at == cyc, popped.tag, cyc, popped.at);
        end
      end else if (sb.size() != 0 && cyc > sb[0].at) begin
        popped = sb.pop_front();
        chk(0, popped.tag, -1, popped.kind);
      end
    end
  end

  initial begin
    int c0;
    step(3);
    rst_n = 1;
    step(2);
    // R1
    chk(sys_clk_en && core_run, "R1 clock/run after reset", {sys_clk_en, core_run}, 3);
    chk(!pd_flag && !to_flag, "R1 flags after reset", {pd_flag, to_flag}, 0);

    // R2 halt entry
    do_halt;
    chk(!sys_clk_en && !core_run, "R2 halted", {sys_clk_en, core_run}, 0);
    chk(pd_flag && !to_flag, "R2 flags on halt", {pd_flag, to_flag}, 2);

    // R4 masked falling and rising edges ignored
    port_in[7] = 0; step(5);
    chk(!sys_clk_en, "R4 masked falling edge ignored", sys_clk_en, 0);
    port_in[7] = 1; step(5);
    chk(!sys_clk_en, "R4 rising edge ignored", sys_clk_en, 0);
    port_in[0] = 0;
    expect_ev(EV_RESUME, 1 + S, "R4 R5 port wake resume");
    step(1);
    chk(sys_clk_en && !core_run, "R5 settling", {sys_clk_en, core_run}, 2);
    drain;
    chk(core_run, "R5 running after resume", core_run, 1);
    port_in[0] = 1; step(1);

    // R3
    wdt_clr = 1; step(1); wdt_clr = 0;
    chk(!pd_flag, "R3 clear command clears pd", pd_flag, 0);
    wdt_clr = 1; halt_cmd = 1; step(1); wdt_clr = 0; halt_cmd = 0;
    chk(pd_flag && !sys_clk_en, "R3 halt wins over clear", pd_flag, 1);

    // R7 interrupt taken (currently halted)
    irq_en = 4'b0001; irq_req[0] = 1;
    expect_ev(EV_TAKE, 2 + S, "R7 interrupt vector take");
    step(1); irq_req = 0;
    drain;

    // R6 stack full -> resume
    do_halt;
    stack_full = 1; irq_req[0] = 1;
    expect_ev(EV_RESUME, 1 + S, "R6 stack full resume");
    step(1); irq_req = 0; stack_full = 0;
    drain;

    // R6 disabled -> resume
    do_halt;
    irq_en = 0; irq_req[3] = 1;
    expect_ev(EV_RESUME, 1 + S, "R6 disabled irq resume");
    step(1); irq_req = 0;
    drain;

    // R6 lowest index chosen: bit1 enabled, bit2 disabled
    do_halt;
    irq_en = 4'b0010; irq_req = 4'b0110;
    expect_ev(EV_TAKE, 2 + S, "R6 lowest index selects take");
    step(1); irq_req = 0;
    drain;

    // R8 pending before halt barred
    irq_req[1] = 1; step(1);
    do_halt;
    step(20);
    chk(!sys_clk_en, "R8 pending irq cannot wake", sys_clk_en, 0);
    irq_en = 4'b0100; irq_req[2] = 1;
    expect_ev(EV_TAKE, 2 + S, "R8 new irq still wakes");
    step(1); irq_req = 0;
    drain;

    // R9 + R11 watchdog beats simultaneous port edge
    do_halt;
    wdt_ovf = 1; port_in[1] = 0;
    expect_ev(EV_WARM, 1 + S, "R9 R11 watchdog warm reset");
    step(1); wdt_ovf = 0; port_in[1] = 1;
    chk(to_flag, "R9 time-out flag set", to_flag, 1);
    drain;
    chk(to_flag && pd_flag, "R9 flags after warm reset", {pd_flag, to_flag}, 3);
    do_halt;
    chk(!to_flag, "R2 halt clears time-out flag", to_flag, 0);

    // R10 external reset while halted, with ignored halt command during settle
    ext_rst = 1; irq_req[0] = 1; irq_en = 4'b0001;
    c0 = cyc;
    step(1); ext_rst = 0; irq_req = 0;
    chk(!pd_flag && !to_flag && !core_run, "R10 flags cleared", {pd_flag, to_flag, core_run}, 0);
    halt_cmd = 1; step(1); halt_cmd = 0;
    chk(sys_clk_en, "R2 halt ignored while settling", sys_clk_en, 1);
    while (cyc < c0 + S) @(negedge clk);
    chk(!core_run, "R10 still settling", core_run, 0);
    step(1);
    chk(core_run && !pd_flag, "R10 run after settle", {core_run, pd_flag}, 2);
    step(5);
    chk(sb.size() == 0, "R10 no pending strobes", sb.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule